// File: doc/BRIEF.md
# Memory request packet formatter (transaction layer, transmit side)

This block turns single memory read or memory write commands into transaction-layer packets and streams them out as 64-bit beats. A command carries the request kind, a 64-bit address, a length in dwords (1 to 1024), and a flag that selects the short (3-dword) or long (4-dword) header form. The command also carries the header side fields: traffic class, attributes, digest and poisoned flags, processing hint, requester ID, tag and byte enables. The block builds the header from these fields.

For a write, payload dwords come from a separate valid/ready stream after the header. A zero filler dword may be placed between the header and the payload, so that the payload starts on the quadword boundary implied by the address. A static input can disable this filler and force dense packing. The output stream is a valid/ready beat interface with start-of-packet, end-of-packet and upper-half-empty flags. Backpressure on the output also holds back the payload input.

Top module: `tlp_tx_formatter`

## Requirements
- R1: Header byte 0 is {fmt[2:0], type[4:0]} with type 00000. Fmt is 000 for a short read, 001 for a long read, 010 for a short write and 011 for a long write. Fmt bit 0 of the field (byte 0 bit 5) is set exactly when the long form is selected.
- R2: The 10-bit length field holds cmd_len modulo 1024, so 1024 dwords encode as 0. Field bits 7:0 are header byte 3. Field bits 9:8 are byte 2 bits 1:0.
- R3: The address goes most-significant byte first. A short header carries address bits 31:2 in bytes 8..11. A long header carries address bits 63:2 in bytes 8..15. The last address byte holds cmd_ph in bits 1:0.
- R4: Byte 1 is {0, tc, 0, attr[2], 00}. Byte 2 is {td, ep, attr[1:0], 00, len[9:8]}. Bytes 4..7 are requester ID (high byte first), tag, and {last_be, first_be}. Header byte 4k sits in bits 31:24 of dword k and byte 4k+3 in bits 7:0. Dwords go two per beat, with the earlier dword in tx_data[31:0].
- R5: With pack_tight low, a write gets one zero filler dword between header and payload in two cases: a short header with address bit 2 = 0, or a long header with address bit 2 = 1. In the other two cases the payload follows the header with no gap.
- R6: With pack_tight high, no filler dword is ever inserted.
- R7: A read is sent as its header dwords only, with no filler and no payload. pl_ready stays low throughout.
- R8: tx_sop is set on the first beat of a packet only, and tx_eop on its last beat only. When the final dword lands in the lower half, tx_hi_empty is set and tx_data[63:32] is zero. Otherwise tx_hi_empty is low.
- R9: While tx_valid is high and tx_ready is low, the beat and its flags hold unchanged and pl_ready is low.
- R10: cmd_ready is high exactly when no accepted packet is still unfinished. It falls after a command is taken and rises in the cycle after the end-of-packet beat is taken. The cycle following an end-of-packet handshake has tx_valid low.
- R11: After synchronous reset: tx_valid low, cmd_ready high, pl_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pack_tight | input | 1 | Suppress the alignment filler dword (change only while idle) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken when both high |
| cmd_write | input | 1 | 1 = memory write, 0 = memory read |
| cmd_wide | input | 1 | 1 = 4-dword header with 64-bit address |
| cmd_addr | input | 64 | Byte address (bits 1:0 ignored) |
| cmd_len | input | 11 | Length in dwords, 1..1024 |
| cmd_tc | input | 3 | Traffic class |
| cmd_attr | input | 3 | Attribute bits |
| cmd_td | input | 1 | Digest-present flag |
| cmd_ep | input | 1 | Poisoned flag |
| cmd_ph | input | 2 | Processing hint |
| cmd_req_id | input | 16 | Requester ID |
| cmd_tag | input | 8 | Tag |
| cmd_last_be | input | 4 | Last dword byte enables |
| cmd_first_be | input | 4 | First dword byte enables |
| pl_valid | input | 1 | Payload dword offered |
| pl_ready | output | 1 | Payload dword taken when both high |
| pl_data | input | 32 | Payload dword |
| tx_valid | output | 1 | Beat valid |
| tx_ready | input | 1 | Sink accepts beat |
| tx_data | output | 64 | Two dwords, earlier in bits 31:0 |
| tx_sop | output | 1 | First beat of packet |
| tx_eop | output | 1 | Last beat of packet |
| tx_hi_empty | output | 1 | Upper dword of this last beat is unused |

## Verification
The hardest case to reach is a stalled sink on the exact cycle when the filler dword or the final payload dword would complete a beat. There the hold rule, the payload stall and the half-empty end flag all act at once. The bench reaches it by crossing both header sizes with both values of address bit 2, with and without tight packing. It runs each case first with the sink always ready and then with randomly withheld ready and payload valid. It also uses odd and even payload lengths, including 1024 dwords, so that the end-of-packet beat falls in both halves.

// File: rtl/tlp_tx_pkg.sv
// Shared sizes and types for the memory request packet formatter.
// Assumes 32-bit dwords packed two per output beat.
package tlp_tx_pkg;
    localparam int DW_BITS   = 32;
    localparam int BEAT_DWS  = 2;
    localparam int BEAT_BITS = DW_BITS * BEAT_DWS;
    localparam int HDR_MAX   = 4;
    localparam int IDX_W     = $clog2(HDR_MAX);
    localparam int LEN_BITS  = 11;
    localparam int ADDR_BITS = 64;

    typedef logic [DW_BITS-1:0] dword_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_HDR,
        SQ_FILL,
        SQ_PAY,
        SQ_DRAIN
    } sq_state_t;

    typedef struct packed {
        logic [2:0]  tc;
        logic [2:0]  attr;
        logic        td;
        logic        ep;
        logic [1:0]  ph;
        logic [15:0] rid;
        logic [7:0]  tag;
        logic [3:0]  last_be;
        logic [3:0]  first_be;
    } hdr_side_t;
endpackage

// File: rtl/tlp_hdr_build.sv
// Combinational header composer: forms up to four header dwords from a
// command and decides whether a filler dword is needed before payload.
// Assumes len is in 1..1024; bits 1:0 of the address are not carried.
module tlp_hdr_build
    import tlp_tx_pkg::*;
(
    input  logic                          is_write,
    input  logic                          wide,
    input  logic                          pack_tight,
    input  logic [ADDR_BITS-1:0]          addr,
    input  logic [LEN_BITS-1:0]           len,
    input  hdr_side_t                     side,
    output logic [HDR_MAX-1:0][DW_BITS-1:0] hdr_dws,
    output logic [IDX_W-1:0]              hdr_last,
    output logic                          need_fill
);
    logic [7:0] b0, b1, b2, b3;
    logic [DW_BITS-1:0] addr_low_dw;
    logic unused_addr_lsb;

    assign unused_addr_lsb = ^addr[1:0];

    // Compose the fixed first dword and the address dwords.
    always_comb begin
        b0 = {1'b0, is_write, wide, 5'b00000};
        b1 = {1'b0, side.tc, 1'b0, side.attr[2], 2'b00};
        b2 = {side.td, side.ep, side.attr[1:0], 2'b00, len[9:8]};
        b3 = len[7:0];
        addr_low_dw = {addr[31:2], side.ph};
        hdr_dws[0] = {b0, b1, b2, b3};
        hdr_dws[1] = {side.rid, side.tag, side.last_be, side.first_be};
        hdr_dws[2] = wide ? addr[63:32] : addr_low_dw;
        hdr_dws[3] = wide ? addr_low_dw : '0;
        hdr_last   = wide ? IDX_W'(3) : IDX_W'(2);
    end

    // Filler rule: payload must start where address bit 2 says it should.
    assign need_fill = is_write && !pack_tight && (wide == addr[2]);
endmodule

// File: rtl/tlp_dw_seq.sv
// Dword sequencer: captures one command, then emits header dwords, the
// optional filler and the payload dwords as a single dword stream.
// Assumes the downstream packer signals take-ability through dw_take and
// reports the end-of-packet handshake through eop_sent.
module tlp_dw_seq
    import tlp_tx_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cmd_valid,
    output logic                            cmd_ready,
    input  logic                            cmd_write,
    input  logic [LEN_BITS-1:0]             cmd_len,
    input  logic [HDR_MAX-1:0][DW_BITS-1:0] hdr_in,
    input  logic [IDX_W-1:0]                hdr_last_in,
    input  logic                            fill_in,
    input  logic                            pl_valid,
    output logic                            pl_ready,
    input  dword_t                          pl_data,
    output logic                            dw_valid,
    output dword_t                          dw_data,
    output logic                            dw_first,
    output logic                            dw_last,
    input  logic                            dw_take,
    input  logic                            eop_sent
);
    sq_state_t                       state;
    logic [HDR_MAX-1:0][DW_BITS-1:0] hdr_q;
    logic [IDX_W-1:0]                hdr_last_q;
    logic [IDX_W-1:0]                idx;
    logic                            fill_q;
    logic                            wr_q;
    logic [LEN_BITS-1:0]             pay_left;
    logic                            dw_fire;
    logic                            hdr_end;

    assign cmd_ready = (state == SQ_IDLE);
    assign hdr_end   = (idx == hdr_last_q);
    assign dw_fire   = dw_valid && dw_take;

    // Present the current dword and its first/last marks.
    always_comb begin
        dw_valid = 1'b0;
        dw_data  = '0;
        dw_first = 1'b0;
        dw_last  = 1'b0;
        pl_ready = 1'b0;
        case (state)
            SQ_HDR: begin
                dw_valid = 1'b1;
                dw_data  = hdr_q[idx];
                dw_first = (idx == '0);
                dw_last  = hdr_end && !wr_q;
            end
            SQ_FILL: dw_valid = 1'b1;
            SQ_PAY: begin
                dw_valid = pl_valid;
                dw_data  = pl_data;
                dw_last  = (pay_left == LEN_BITS'(1));
                pl_ready = dw_take;
            end
            default: ;
        endcase
    end

    // Step through the packet phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            hdr_q      <= '0;
            hdr_last_q <= '0;
            idx        <= '0;
            fill_q     <= 1'b0;
            wr_q       <= 1'b0;
            pay_left   <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (cmd_valid) begin
                    hdr_q      <= hdr_in;
                    hdr_last_q <= hdr_last_in;
                    fill_q     <= fill_in;
                    wr_q       <= cmd_write;
                    pay_left   <= cmd_len;
                    idx        <= '0;
                    state      <= SQ_HDR;
                end
                SQ_HDR: if (dw_fire) begin
                    if (!hdr_end)     idx   <= idx + 1'b1;
                    else if (!wr_q)   state <= SQ_DRAIN;
                    else if (fill_q)  state <= SQ_FILL;
                    else              state <= SQ_PAY;
                end
                SQ_FILL: if (dw_fire) state <= SQ_PAY;
                SQ_PAY: if (dw_fire) begin
                    pay_left <= pay_left - 1'b1;
                    if (dw_last) state <= SQ_DRAIN;
                end
                SQ_DRAIN: if (eop_sent) state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // A read never asks for payload.
    p_read_no_payload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_PAY) |-> wr_q);
endmodule

// File: rtl/tlp_beat_pack.sv
// Beat packer: pairs dwords into 64-bit beats (earlier dword low) and
// holds each beat in an output register until the sink takes it.
// Assumes dw_first/dw_last mark packet bounds on the incoming stream.
module tlp_beat_pack
    import tlp_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dw_valid,
    input  dword_t               dw_data,
    input  logic                 dw_first,
    input  logic                 dw_last,
    output logic                 dw_take,
    output logic                 tx_valid,
    input  logic                 tx_ready,
    output logic [BEAT_BITS-1:0] tx_data,
    output logic                 tx_sop,
    output logic                 tx_eop,
    output logic                 tx_hi_empty
);
    dword_t lo_q;
    logic   lo_full;
    logic   lo_sop;
    logic   dw_fire;

    assign dw_take = !tx_valid || tx_ready;
    assign dw_fire = dw_valid && dw_take;

    // Fill the lower half, then emit a full or half-empty beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q        <= '0;
            lo_full     <= 1'b0;
            lo_sop      <= 1'b0;
            tx_valid    <= 1'b0;
            tx_data     <= '0;
            tx_sop      <= 1'b0;
            tx_eop      <= 1'b0;
            tx_hi_empty <= 1'b0;
        end else if (dw_take) begin
            tx_valid <= 1'b0;
            if (dw_fire) begin
                if (lo_full) begin
                    tx_valid    <= 1'b1;
                    tx_data     <= {dw_data, lo_q};
                    tx_sop      <= lo_sop;
                    tx_eop      <= dw_last;
                    tx_hi_empty <= 1'b0;
                    lo_full     <= 1'b0;
                end else if (dw_last) begin
                    tx_valid    <= 1'b1;
                    tx_data     <= {{DW_BITS{1'b0}}, dw_data};
                    tx_sop      <= dw_first;
                    tx_eop      <= 1'b1;
                    tx_hi_empty <= 1'b1;
                end else begin
                    lo_q    <= dw_data;
                    lo_full <= 1'b1;
                    lo_sop  <= dw_first;
                end
            end
        end
    end

    p_hold_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop)
                                     && $stable(tx_eop) && $stable(tx_hi_empty)));

    p_empty_on_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_hi_empty) |-> (tx_eop && tx_data[BEAT_BITS-1:DW_BITS] == '0));
endmodule

// File: rtl/tlp_tx_formatter.sv
// Memory request packet formatter top: header composer, dword sequencer
// and beat packer. Assumes pack_tight changes only while cmd_ready is high.
module tlp_tx_formatter
    import tlp_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pack_tight,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic                 cmd_write,
    input  logic                 cmd_wide,
    input  logic [63:0]          cmd_addr,
    input  logic [10:0]          cmd_len,
    input  logic [2:0]           cmd_tc,
    input  logic [2:0]           cmd_attr,
    input  logic                 cmd_td,
    input  logic                 cmd_ep,
    input  logic [1:0]           cmd_ph,
    input  logic [15:0]          cmd_req_id,
    input  logic [7:0]           cmd_tag,
    input  logic [3:0]           cmd_last_be,
    input  logic [3:0]           cmd_first_be,
    input  logic                 pl_valid,
    output logic                 pl_ready,
    input  logic [31:0]          pl_data,
    output logic                 tx_valid,
    input  logic                 tx_ready,
    output logic [63:0]          tx_data,
    output logic                 tx_sop,
    output logic                 tx_eop,
    output logic                 tx_hi_empty
);
    hdr_side_t                       side;
    logic [HDR_MAX-1:0][DW_BITS-1:0] hdr_dws;
    logic [IDX_W-1:0]                hdr_last;
    logic                            need_fill;
    logic                            dw_valid, dw_first, dw_last, dw_take;
    dword_t                          dw_data;
    logic                            eop_sent;

    // Gather the side fields of the header.
    always_comb begin
        side.tc       = cmd_tc;
        side.attr     = cmd_attr;
        side.td       = cmd_td;
        side.ep       = cmd_ep;
        side.ph       = cmd_ph;
        side.rid      = cmd_req_id;
        side.tag      = cmd_tag;
        side.last_be  = cmd_last_be;
        side.first_be = cmd_first_be;
    end

    assign eop_sent = tx_valid && tx_ready && tx_eop;

    tlp_hdr_build i_hdr (
        .is_write  (cmd_write),
        .wide      (cmd_wide),
        .pack_tight(pack_tight),
        .addr      (cmd_addr),
        .len       (cmd_len),
        .side      (side),
        .hdr_dws   (hdr_dws),
        .hdr_last  (hdr_last),
        .need_fill (need_fill)
    );

    tlp_dw_seq i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_write  (cmd_write),
        .cmd_len    (cmd_len),
        .hdr_in     (hdr_dws),
        .hdr_last_in(hdr_last),
        .fill_in    (need_fill),
        .pl_valid   (pl_valid),
        .pl_ready   (pl_ready),
        .pl_data    (pl_data),
        .dw_valid   (dw_valid),
        .dw_data    (dw_data),
        .dw_first   (dw_first),
        .dw_last    (dw_last),
        .dw_take    (dw_take),
        .eop_sent   (eop_sent)
    );

    tlp_beat_pack i_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .dw_valid   (dw_valid),
        .dw_data    (dw_data),
        .dw_first   (dw_first),
        .dw_last    (dw_last),
        .dw_take    (dw_take),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .tx_data    (tx_data),
        .tx_sop     (tx_sop),
        .tx_eop     (tx_eop),
        .tx_hi_empty(tx_hi_empty)
    );

    p_payload_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |-> !pl_ready);

    p_idle_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !tx_valid);

    p_gap_after_eop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eop_sent |=> (!tx_valid && cmd_ready));
endmodule

// File: tb/test_tlp_tx_formatter.sv
module test_tlp_tx_formatter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pack_tight = 1'b0;
    logic        cmd_valid = 1'b0, cmd_ready;
    logic        cmd_write = 1'b0, cmd_wide = 1'b0;
    logic [63:0] cmd_addr = '0;
    logic [10:0] cmd_len = 11'd1;
    logic [2:0]  cmd_tc = 3'b101, cmd_attr = 3'b110;
    logic        cmd_td = 1'b1, cmd_ep = 1'b0;
    logic [1:0]  cmd_ph = 2'b11;
    logic [15:0] cmd_req_id = 16'hA5C3;
    logic [7:0]  cmd_tag = '0;
    logic [3:0]  cmd_last_be = 4'hC, cmd_first_be = 4'h3;
    logic        pl_valid = 1'b0, pl_ready;
    logic [31:0] pl_data = '0;
    logic        tx_valid, tx_ready = 1'b0;
    logic [63:0] tx_data;
    logic        tx_sop, tx_eop, tx_hi_empty;

    always #5 clk = ~clk;

    tlp_tx_formatter i_tlp_tx_formatter (.*);

    int n_vec = 0, n_bad = 0, cyc = 0, cmd_no = 0;
    bit rdy_rand = 0, pv_rand = 0;
    logic [63:0] exp_data[$];
    logic [2:0]  exp_flag[$];
    string       exp_tag[$];
    logic [31:0] pay_q[$];
    bit          hold_prev = 0;
    logic [63:0] hold_data;
    logic [2:0]  hold_flag;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Reference model: build the expected beats of one packet from the rules.
    task automatic build(input bit wr, input bit wide, input logic [63:0] a, input int len, input bit tight);
        logic [7:0]  hb[16];
        logic [31:0] dws[$];
        logic [9:0]  lf;
        int          nh;
        string       tg;
        lf = len[9:0];
        nh = wide ? 4 : 3;
        hb[0] = {1'b0, wr, wide, 5'b0};
        hb[1] = {1'b0, cmd_tc, 1'b0, cmd_attr[2], 2'b00};
        hb[2] = {cmd_td, cmd_ep, cmd_attr[1:0], 2'b00, lf[9:8]};
        hb[3] = lf[7:0];
        hb[4] = cmd_req_id[15:8];
        hb[5] = cmd_req_id[7:0];
        hb[6] = cmd_tag;
        hb[7] = {cmd_last_be, cmd_first_be};
        for (int k = 0; k < 8; k++) hb[8 + k] = '0;
        if (wide) begin
            for (int k = 0; k < 8; k++) hb[8 + k] = a[63 - 8*k -: 8];
            hb[15] = {a[7:2], cmd_ph};
        end else begin
            for (int k = 0; k < 4; k++) hb[8 + k] = a[31 - 8*k -: 8];
            hb[11] = {a[7:2], cmd_ph};
        end
        for (int k = 0; k < nh; k++) dws.push_back({hb[4*k], hb[4*k+1], hb[4*k+2], hb[4*k+3]});
        if (wr && !tight && ((!wide && !a[2]) || (wide && a[2]))) dws.push_back(32'h0);
        if (wr) for (int i = 0; i < len; i++) begin
            dws.push_back(32'hD000_0000 | (cmd_no << 16) | i);
            pay_q.push_back(32'hD000_0000 | (cmd_no << 16) | i);
        end
        tg = !wr ? "R1 R2 R3 R4 R7" : (tight ? "R1 R2 R3 R4 R6" : "R1 R2 R3 R4 R5");
        for (int i = 0; i < dws.size(); i += 2) begin
            bit last = (i + 2 >= dws.size());
            if (i + 1 < dws.size()) begin
                exp_data.push_back({dws[i+1], dws[i]});
                exp_flag.push_back({i == 0, last, 1'b0});
            end else begin
                exp_data.push_back({32'h0, dws[i]});
                exp_flag.push_back({i == 0, 1'b1, 1'b1});
            end
            exp_tag.push_back(tg);
        end
    endtask

    task automatic do_cmd(input bit wr, input bit wide, input logic [63:0] a, input int len);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_wide = wide; cmd_addr = a;
        cmd_len = len[10:0]; cmd_tag = cmd_no[7:0];
        forever begin
            #2;
            if (cmd_ready) break;
            @(negedge clk);
        end
        build(wr, wide, a, len, pack_tight);
        cmd_no++;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle;
        while (exp_data.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Drive sink and payload, then compare against the model every clock.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog R10 actual=%0d expected<150000", cyc);
            summary();
            $finish;
        end
        if (rst_n) begin
            tx_ready = rdy_rand ? (($urandom % 3) != 0) : 1'b1;
            if (pay_q.size() > 0 && (!pv_rand || ($urandom % 4) != 0)) begin
                pl_valid = 1'b1; pl_data = pay_q[0];
            end else begin
                pl_valid = 1'b0; pl_data = '0;
            end
            #1;
            if (hold_prev)
                chk(tx_valid && tx_data == hold_data && {tx_sop, tx_eop, tx_hi_empty} == hold_flag,
                    "R9 beat held", tx_data, hold_data);
            hold_prev = tx_valid && !tx_ready;
            hold_data = tx_data;
            hold_flag = {tx_sop, tx_eop, tx_hi_empty};
            if (tx_valid && !tx_ready) chk(!pl_ready, "R9 payload stalled", 64'(pl_ready), 64'd0);
            chk(cmd_ready == (exp_data.size() == 0), "R10 cmd_ready", 64'(cmd_ready), 64'(exp_data.size() == 0));
            if (tx_valid && tx_ready) begin
                if (exp_data.size() == 0) begin
                    chk(1'b0, "R8 unexpected beat", tx_data, 64'd0);
                end else begin
                    chk(tx_data == exp_data[0], exp_tag[0], tx_data, exp_data[0]);
                    chk({tx_sop, tx_eop, tx_hi_empty} == exp_flag[0], "R8 sop/eop/hi_empty",
                        64'({tx_sop, tx_eop, tx_hi_empty}), 64'(exp_flag[0]));
                    void'(exp_data.pop_front());
                    void'(exp_flag.pop_front());
                    void'(exp_tag.pop_front());
                end
            end
            if (pl_valid && pl_ready) void'(pay_q.pop_front());
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #3;
        // R11: state after reset
        chk(!tx_valid && cmd_ready && !pl_ready, "R11 reset state",
            64'({tx_valid, cmd_ready, pl_ready}), 64'(3'b010));

        for (int pass = 0; pass < 2; pass++) begin
            rdy_rand = pass[0]; pv_rand = pass[0];
            pack_tight = 1'b0;
            do_cmd(0, 0, 64'h0000_0000_1234_5670, 1);     // R7 short read, hi half empty
            do_cmd(0, 1, 64'h89AB_CDEF_0246_8ACC, 1024);  // R2 length 1024 -> 0, R3 long
            do_cmd(1, 0, 64'h0000_0000_4000_0010, 2);     // R5 short aligned: filler
            do_cmd(1, 0, 64'h0000_0000_4000_0014, 3);     // R5 short unaligned: packed
            do_cmd(1, 1, 64'h1111_2222_3333_4440, 1);     // R5 long aligned: packed
            do_cmd(1, 1, 64'h1111_2222_3333_4444, 2);     // R5 long unaligned: filler
            wait_idle();
            pack_tight = 1'b1;                            // R6 tight packing
            do_cmd(1, 0, 64'h0000_0000_0000_0100, 2);
            do_cmd(1, 1, 64'hFEDC_0000_0000_0104, 3);
            wait_idle();
            pack_tight = 1'b0;
        end
        rdy_rand = 1; pv_rand = 1;
        do_cmd(1, 0, 64'h0000_0000_0000_2000, 1024);      // R2 long write payload
        for (int i = 0; i < 30; i++) begin
            wait_idle();
            pack_tight = ($urandom % 4) == 0;
            do_cmd($urandom % 2, $urandom % 2, {$urandom, $urandom}, 1 + ($urandom % 40));
        end
        wait_idle();
        repeat (3) @(negedge clk);
        chk(pay_q.size() == 0, "R7 payload fully consumed", 64'(pay_q.size()), 64'd0);
        summary();
        $finish;
    end
endmodule